// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events from a small group of core sources (timer rollover, external pin edge, port change) and a larger group of peripheral sources (memory write complete, converter done, serial receive and transmit, synchronous serial port, capture/compare, timer match, timer rollover). Each event sets a sticky flag. The flag sets whatever its enables hold, so software can poll pending events with interrupts off. A single request line to the CPU is formed from these flags. That line is gated by per-source enables, by a group enable that covers only the peripheral sources, and by a global enable that covers everything.

Software reads and writes three 8-bit registers through a register-select port: a core control register, a peripheral enable register and a peripheral flag register. Two peripheral flags follow data-buffer state. The serial receive flag is cleared by a strobe that marks a read of the receive data register. The serial transmit flag is cleared by a strobe that marks a write of the transmit data register. Software cannot write either flag. When the CPU accepts an interrupt it pulses an acknowledge, which drops the global enable. A return pulse raises it again.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, all three registers read 8'h00 and `irq` is low.
- R2: A high on `core_evt[i]` or `per_evt[i]` at a clock edge sets the matching flag at that edge, whatever the enables hold. The core flags are at bits 2..0 of the core register (bit 2 timer, bit 1 pin, bit 0 port change). Peripheral flag i is bit i of the peripheral flag register.
- R3: A flag stays set until it is cleared by a software write of 0 to its bit, or, for the auto-cleared flags only, by their strobe.
- R4: When a hardware event and any clear (a software write or a strobe) hit the same flag at the same edge, the flag ends up set.
- R5: Peripheral flag bit 5 (receive) clears on `rxd_read` and bit 4 (transmit) clears on `txd_write`. Software writes to these two bits have no effect.
- R6: `irq` = global AND (any core flag with its enable OR (group AND any peripheral flag with its enable)). It follows register state with no added cycle.
- R7: `ack` clears the global enable at the edge. It wins over `reti` and over a software write in the same cycle.
- R8: `reti` without `ack` sets the global enable at the edge. It wins over a software write.
- R9: Register select 0 is the core register, laid out as {global, group, timer en, pin en, change en, timer flag, pin flag, change flag} from bit 7 down to bit 0. Select 1 is the peripheral enable register and select 2 is the peripheral flag register. Select 3 reads 8'h00 and ignores writes.
- R10: A software write of 1 to a flag bit that is not auto-cleared sets that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_evt | input | 3 | Core event pulses (2 timer, 1 pin, 0 port change) |
| per_evt | input | 8 | Peripheral event pulses, bit i sets peripheral flag i |
| rxd_read | input | 1 | Strobe: receive data register was read |
| txd_write | input | 1 | Strobe: transmit data register was written |
| reg_sel | input | 2 | Register select for read and write |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| ack | input | 1 | CPU accepts the interrupt |
| reti | input | 1 | CPU returns from the interrupt |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench targets the collisions. An event and a software clear on the same flag in the same cycle must leave the flag set; a design that lets the clear win loses that event for good. `ack` with `reti` must drop the global enable; a design with that priority reversed re-enters the handler at once. Software writes must not touch the receive and transmit flags; a design that lets them through lets software hide a full receive buffer. The bench also raises a peripheral flag with its enable on while the group enable is off, where a design that skips the group gate would raise `irq`. Unused select 3 must neither alias onto a real register nor return stale data.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CORE_N = 3;
  localparam int PER_N  = 8;
  localparam int REG_W  = 8;
  localparam int RX_POS = 5;
  localparam int TX_POS = 4;

  typedef enum logic [1:0] {
    SEL_CORE = 2'd0,
    SEL_PEN  = 2'd1,
    SEL_PFL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Next value of one flag: a hardware set beats every clear.
  function automatic logic flag_next(logic cur, logic hw_set, logic sw_we,
                                     logic sw_val, logic aclr);
    if (hw_set)     return 1'b1;
    else if (aclr)  return 1'b0;
    else if (sw_we) return sw_val;
    else            return cur;
  endfunction

  // Next global enable: acknowledge first, then return, then software.
  function automatic logic glob_next(logic cur, logic ack, logic reti,
                                     logic sw_we, logic sw_val);
    if (ack)        return 1'b0;
    else if (reti)  return 1'b1;
    else if (sw_we) return sw_val;
    else            return cur;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          N         = 8,
  parameter logic [N-1:0] AUTO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         sw_we,
  input  logic [N-1:0] sw_data,
  input  logic [N-1:0] aclr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    logic sw_ok;
    logic ac_ok;
    assign sw_ok = sw_we & ~AUTO_MASK[i];
    assign ac_ok = aclr[i] & AUTO_MASK[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= irq_pkg::flag_next(bit_q, evt[i], sw_ok, sw_data[i], ac_ok);
    end
    assign flag[i] = bit_q;
  end

  // R2 / R4: an event leaves its flag set, regardless of any clear.
  a_r2_evt_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag & $past(evt)) == $past(evt)));
  // R5: strobe on an auto bit without an event clears it.
  a_r5_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((aclr & ~evt & AUTO_MASK) != '0) |=> ((flag & $past(aclr & ~evt & AUTO_MASK)) == '0));
  // R3: no event, no write, no strobe: flags hold.
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && !sw_we && aclr == '0) |=> $stable(flag));
  // R10: software 1 on a writable bit sets it.
  a_r10_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && ((sw_data & ~AUTO_MASK) != '0)) |=>
      ((flag & $past(sw_data & ~AUTO_MASK)) == $past(sw_data & ~AUTO_MASK)));
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int NC    = 3,
  parameter int NP    = 8,
  parameter int REG_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_we,
  input  logic          pen_we,
  input  logic [REG_W-1:0] wr_data,
  input  logic          ack,
  input  logic          reti,
  output logic          glob_en,
  output logic          grp_en,
  output logic [NC-1:0] core_en,
  output logic [NP-1:0] per_en
);
  localparam int GLB_POS = 2*NC + 1;
  localparam int GRP_POS = 2*NC;
  localparam int EN_LO   = NC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      grp_en  <= 1'b0;
      core_en <= '0;
      per_en  <= '0;
    end else begin
      glob_en <= irq_pkg::glob_next(glob_en, ack, reti, core_we, wr_data[GLB_POS]);
      if (core_we) begin
        grp_en  <= wr_data[GRP_POS];
        core_en <= wr_data[EN_LO +: NC];
      end
      if (pen_we) per_en <= wr_data[NP-1:0];
    end
  end

  a_r7_ack_drops_global: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !glob_en);
  a_r8_reti_raises_global: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack) |=> glob_en);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NC = 3,
  parameter int NP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glob_en,
  input  logic          grp_en,
  input  logic [NC-1:0] core_en,
  input  logic [NC-1:0] core_fl,
  input  logic [NP-1:0] per_en,
  input  logic [NP-1:0] per_fl,
  output logic          core_hit,
  output logic          per_hit,
  output logic          irq
);
  assign core_hit = |(core_en & core_fl);
  assign per_hit  = grp_en & (|(per_en & per_fl));
  assign irq      = glob_en & (core_hit | per_hit);

  a_r6_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glob_en);
  a_r6_core_path: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && ((core_en & core_fl) != '0)) |-> irq);
  a_r6_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_en && ((core_en & core_fl) == '0)) |-> !irq);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int CORE_N = irq_pkg::CORE_N,
  parameter int PER_N  = irq_pkg::PER_N,
  parameter int REG_W  = irq_pkg::REG_W,
  parameter int RX_POS = irq_pkg::RX_POS,
  parameter int TX_POS = irq_pkg::TX_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CORE_N-1:0] core_evt,
  input  logic [PER_N-1:0]  per_evt,
  input  logic              rxd_read,
  input  logic              txd_write,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ack,
  input  logic              reti,
  output logic              irq
);
  import irq_pkg::*;

  localparam logic [PER_N-1:0] PER_AUTO = (PER_N'(1) << RX_POS) | (PER_N'(1) << TX_POS);

  logic              wr_core, wr_pen, wr_pfl;
  logic              glob_en, grp_en;
  logic [CORE_N-1:0] core_en, core_fl;
  logic [PER_N-1:0]  per_en, per_fl, per_aclr;
  logic              core_hit, per_hit;

  assign wr_core = wr_en && (reg_sel == SEL_CORE);
  assign wr_pen  = wr_en && (reg_sel == SEL_PEN);
  assign wr_pfl  = wr_en && (reg_sel == SEL_PFL);

  always_comb begin
    per_aclr         = '0;
    per_aclr[RX_POS] = rxd_read;
    per_aclr[TX_POS] = txd_write;
  end

  irq_flag_bank #(.N(CORE_N), .AUTO_MASK('0)) u_core_flags (
    .clk(clk), .rst_n(rst_n), .evt(core_evt), .sw_we(wr_core),
    .sw_data(wr_data[CORE_N-1:0]), .aclr('0), .flag(core_fl));

  irq_flag_bank #(.N(PER_N), .AUTO_MASK(PER_AUTO)) u_per_flags (
    .clk(clk), .rst_n(rst_n), .evt(per_evt), .sw_we(wr_pfl),
    .sw_data(wr_data[PER_N-1:0]), .aclr(per_aclr), .flag(per_fl));

  irq_enable_regs #(.NC(CORE_N), .NP(PER_N), .REG_W(REG_W)) u_enables (
    .clk(clk), .rst_n(rst_n), .core_we(wr_core), .pen_we(wr_pen),
    .wr_data(wr_data), .ack(ack), .reti(reti), .glob_en(glob_en),
    .grp_en(grp_en), .core_en(core_en), .per_en(per_en));

  irq_combine #(.NC(CORE_N), .NP(PER_N)) u_combine (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .grp_en(grp_en),
    .core_en(core_en), .core_fl(core_fl), .per_en(per_en), .per_fl(per_fl),
    .core_hit(core_hit), .per_hit(per_hit), .irq(irq));

  always_comb begin
    unique case (reg_sel)
      SEL_CORE: rd_data = {glob_en, grp_en, core_en, core_fl};
      SEL_PEN:  rd_data = per_en;
      SEL_PFL:  rd_data = per_fl;
      default:  rd_data = '0;
    endcase
  end

  // R7: the request falls right after an acknowledge.
  a_r7_irq_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  // R9: a write to select 3 leaves the core register unchanged.
  a_r9_sel3_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_NONE && !ack && !reti && core_evt == '0) |=>
      $stable({glob_en, grp_en, core_en, core_fl}));
endmodule

// File: tb/irq_ctrl_top_bench.sv
module irq_ctrl_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] core_evt = '0;
  logic [7:0] per_evt = '0;
  logic       rxd_read = 1'b0, txd_write = 1'b0;
  logic [1:0] reg_sel = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ack = 1'b0, reti = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  // reference state
  bit       m_glob, m_grp;
  bit [2:0] m_cen, m_cfl;
  bit [7:0] m_pen, m_pfl;

  always #5 clk = ~clk;

  irq_ctrl_top u_irq_ctrl_top (
    .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .per_evt(per_evt),
    .rxd_read(rxd_read), .txd_write(txd_write), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
    .reti(reti), .irq(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_irq();
    bit c = 0, p = 0;
    for (int i = 0; i < 3; i++) if (m_cen[i] && m_cfl[i]) c = 1;
    for (int i = 0; i < 8; i++) if (m_pen[i] && m_pfl[i]) p = 1;
    return m_glob && (c || (m_grp && p));
  endfunction

  function automatic int model_rd(int sel);
    case (sel)
      0: return {m_glob, m_grp, m_cen, m_cfl};
      1: return m_pen;
      2: return m_pfl;
      default: return 0;
    endcase
  endfunction

  // reference model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_glob <= 0; m_grp <= 0; m_cen <= '0; m_cfl <= '0; m_pen <= '0; m_pfl <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (core_evt[i]) m_cfl[i] <= 1;
        else if (wr_en && reg_sel == 0) m_cfl[i] <= wr_data[i];
      if (wr_en && reg_sel == 0) begin
        m_cen <= wr_data[5:3];
        m_grp <= wr_data[6];
      end
      if (ack) m_glob <= 0;
      else if (reti) m_glob <= 1;
      else if (wr_en && reg_sel == 0) m_glob <= wr_data[7];
      if (wr_en && reg_sel == 1) m_pen <= wr_data;
      for (int i = 0; i < 8; i++)
        if (per_evt[i]) m_pfl[i] <= 1;
        else if (i == 5) begin if (rxd_read) m_pfl[i] <= 0; end
        else if (i == 4) begin if (txd_write) m_pfl[i] <= 0; end
        else if (wr_en && reg_sel == 2) m_pfl[i] <= wr_data[i];
    end
  end

  // per-cycle comparison, 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      chk("R6 irq vs model", irq, model_irq());
      chk("R9 rd_data vs model", rd_data, model_rd(reg_sel));
    end
  end

  task automatic wr(input int sel, input int data);
    reg_sel = sel[1:0]; wr_data = data[7:0]; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string req, input int sel, input int exp);
    reg_sel = sel[1:0];
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 core reg", 0, 8'h00); rd("R1 per en", 1, 8'h00); rd("R1 per flag", 2, 8'h00);
    chk("R1 irq", irq, 0);
    // R2 flag latches with everything disabled
    core_evt = 3'b100; @(negedge clk); core_evt = '0;
    rd("R2 core timer flag", 0, 8'h04); chk("R2 no irq while disabled", irq, 0);
    // R6 global + timer enable
    wr(0, 8'hA4); rd("R6 core reg", 0, 8'hA4); chk("R6 irq raised", irq, 1);
    // R7 ack
    ack = 1; @(negedge clk); ack = 0;
    rd("R7 ack clears global", 0, 8'h24); chk("R7 irq low", irq, 0);
    reti = 1; ack = 1; @(negedge clk); reti = 0; ack = 0;
    rd("R7 ack beats reti", 0, 8'h24);
    // R8 reti, also beats a software write
    reti = 1; wr(0, 8'h24); reti = 0;
    rd("R8 reti sets global", 0, 8'hA4); chk("R8 irq back", irq, 1);
    // R3 software clear
    wr(0, 8'hA0); rd("R3 sw clear", 0, 8'hA0); chk("R3 irq low", irq, 0);
    // R4 event beats clear
    core_evt = 3'b100; wr(0, 8'hA0); core_evt = '0;
    rd("R4 event beats sw clear", 0, 8'hA4);
    wr(0, 8'hA0);
    // peripheral receive flag
    per_evt = 8'h20; @(negedge clk); per_evt = '0;
    rd("R2 per rx flag", 2, 8'h20); chk("R6 per not enabled", irq, 0);
    wr(1, 8'h20); chk("R6 group gate blocks", irq, 0);
    wr(0, 8'hE0); chk("R6 group path raises", irq, 1);
    wr(2, 8'h00); rd("R5 sw cannot clear rx", 2, 8'h20);
    rxd_read = 1; @(negedge clk); rxd_read = 0;
    rd("R5 rx read clears", 2, 8'h00); chk("R5 irq drops", irq, 0);
    per_evt = 8'h10; txd_write = 1; @(negedge clk); per_evt = '0; txd_write = 0;
    rd("R4 event beats strobe", 2, 8'h10);
    txd_write = 1; @(negedge clk); txd_write = 0;
    rd("R5 tx write clears", 2, 8'h00);
    // R10 software set, auto bits untouched
    wr(2, 8'hFF); rd("R10 sw set flags", 2, 8'hCF);
    wr(1, 8'h01); chk("R10 irq from sw flag", irq, 1);
    // R9 unused select
    wr(3, 8'hFF);
    rd("R9 sel3 reads zero", 3, 8'h00); rd("R9 core kept", 0, 8'hE0);
    rd("R9 pen kept", 1, 8'h01); rd("R9 pfl kept", 2, 8'hCF);
    // random phase against the model
    for (int n = 0; n < 2000; n++) begin
      core_evt  = (($urandom % 4) == 0) ? 3'($urandom) : '0;
      per_evt   = (($urandom % 4) == 0) ? 8'($urandom) : '0;
      rxd_read  = ($urandom % 5) == 0;
      txd_write = ($urandom % 5) == 0;
      reg_sel   = 2'($urandom);
      wr_en     = ($urandom % 3) == 0;
      wr_data   = 8'($urandom);
      ack       = ($urandom % 7) == 0;
      reti      = ($urandom % 6) == 0;
      @(negedge clk);
    end
    {core_evt, per_evt, rxd_read, txd_write, wr_en, ack, reti} = '0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule